// File: doc/BRIEF.md
# Set-Dueling Insertion Policy Controller

This block decides, for every line filled into a set-associative cache, whether the new line enters its set's recency stack at the most-recently-used end or at the least-recently-used end. Two insertion policies compete. The first is conventional insertion, where every fill goes to MRU. The second is bimodal insertion, where a fill goes to MRU only on a rare pseudo-random draw and goes to LRU otherwise. A handful of sets always use one policy or the other. Misses in these sets move one shared saturating counter up or down, and the top bit of that counter picks the policy for every other set.

The cache controller reports each miss by pulsing `miss_valid` with the set index. It requests a decision by pulsing `fill_valid` with the set index of the fill, and one cycle later reads the answer on `fill_mru`, qualified by `fill_ack`. Promotion on reuse is left to the recency logic: a hit always promotes to MRU, whatever the policy. Each set index falls into one of three groups: the LRU leader group (`GRP_LEAD_LRU`), the bimodal leader group (`GRP_LEAD_BIP`) and the follower group (`GRP_FOLLOW`). The counter moves between its floor (0), its reset midpoint and its ceiling (all ones) one step per leader miss. The follower policy changes when the counter crosses between the midpoint and the value just below it.

Top module: `insertion_duel_ctrl`

## Requirements
- R1: A set index whose low `GROUP_W` bits (default 5) are all zero is an LRU leader. One whose low bits are all ones is a bimodal leader. Every other index is a follower.
- R2: A fill to an LRU leader set always returns `fill_mru` = 1.
- R3: A fill to a bimodal leader set returns `fill_mru` = 1 exactly when the low `EPS_W` bits (default 5) of the LFSR are zero in the cycle the request is sampled, and 0 otherwise. With the defaults this happens with probability 1/32.
- R4: A miss in an LRU leader set adds one to the policy counter, and a miss in a bimodal leader set subtracts one. A miss in a follower set leaves the counter unchanged.
- R5: The counter saturates. An increment at all ones keeps it at all ones, and a decrement at zero keeps it at zero.
- R6: Reset puts the counter at 2^(CNT_W-1) (default CNT_W = 10, giving 512, top bit 1), so followers start with bimodal insertion.
- R7: When the counter's top bit is 0, follower fills always return 1. When it is 1, follower fills follow the bimodal rule of R3.
- R8: `fill_ack` rises exactly one cycle after each cycle with `fill_valid` high, and it and `fill_mru` are 0 in every other cycle, including during reset.
- R9: The LFSR is 16 bits wide. It shifts right in Galois form with feedback mask 0xB400 (the mask is XORed in when the outgoing bit is 1), resets to 0xACE1, and advances on every clock after reset whether or not traffic is present.
- R10: When a miss and a fill arrive in the same cycle, the fill decision uses the counter value from before that miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A cache miss occurred this cycle |
| miss_set | input | SET_W | Set index of the miss |
| fill_valid | input | 1 | Insertion decision requested this cycle |
| fill_set | input | SET_W | Set index of the fill |
| fill_ack | output | 1 | Decision valid, one cycle after the request |
| fill_mru | output | 1 | 1: insert at MRU, 0: insert at LRU |

## Verification
The hardest case to reach is the follower policy flip at the counter midpoint, together with both saturation ends. Each of these needs hundreds of leader misses in one direction before the effect can be seen, and the effect shows up only in follower fills whose LFSR draw is nonzero. The stimulus drives 600 LRU leader misses to pin the counter at its ceiling, then exactly 511 bimodal leader misses, and then one more, while it requests a follower fill every cycle. It then drives the counter to the floor and back up to the value just below the midpoint, and places a miss and a fill in the same cycle there. A seeded random phase follows, in which leader sets are deliberately over-represented.

// File: rtl/insdu_pkg.sv
package insdu_pkg;
    typedef enum logic [1:0] {
        GRP_FOLLOW   = 2'd0,
        GRP_LEAD_LRU = 2'd1,
        GRP_LEAD_BIP = 2'd2
    } grp_e;
endpackage

// File: rtl/insdu_classify.sv
module insdu_classify
    import insdu_pkg::*;
#(
    parameter int SET_W   = 10,
    parameter int GROUP_W = 5
) (
    input  logic [SET_W-1:0] set_idx,
    output grp_e             grp
);
    localparam logic [GROUP_W-1:0] LRU_SLOT = '0;
    localparam logic [GROUP_W-1:0] BIP_SLOT = '1;

    logic [GROUP_W-1:0] slot;
    logic               unused_hi;

    assign slot      = set_idx[GROUP_W-1:0];
    assign unused_hi = ^set_idx;

    // R1: leader groups are decided by the position within each block of sets
    always_comb begin
        if (slot == LRU_SLOT)      grp = GRP_LEAD_LRU;
        else if (slot == BIP_SLOT) grp = GRP_LEAD_BIP;
        else                       grp = GRP_FOLLOW;
    end
endmodule

// File: rtl/insdu_lfsr.sv
module insdu_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] MASK = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    logic [W-1:0] state_d;

    // R9: Galois right shift, free running
    always_comb begin
        state_d = state >> 1;
        if (state[0]) state_d = state_d ^ MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= state_d;
    end
endmodule

// File: rtl/insdu_duel_cnt.sv
module insdu_duel_cnt #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up,
    input  logic             dn,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MIN = '0;
    localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(1) << (CNT_W - 1);

    logic [CNT_W-1:0] cnt_d;

    // R4, R5: single step per leader miss, clamped at both ends
    always_comb begin
        cnt_d = cnt;
        unique case ({up, dn})
            2'b10:   if (cnt != CNT_MAX) cnt_d = cnt + 1'b1;
            2'b01:   if (cnt != CNT_MIN) cnt_d = cnt - 1'b1;
            default: cnt_d = cnt;
        endcase
    end

    // R6: reset to the midpoint
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= CNT_MID;
        else        cnt <= cnt_d;
    end
endmodule

// File: rtl/insertion_duel_ctrl.sv
module insertion_duel_ctrl
    import insdu_pkg::*;
#(
    parameter int SET_W   = 10,
    parameter int GROUP_W = 5,
    parameter int CNT_W   = 10,
    parameter int LFSR_W  = 16,
    parameter int EPS_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [SET_W-1:0] miss_set,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] fill_set,
    output logic             fill_ack,
    output logic             fill_mru
);
    grp_e              miss_grp;
    grp_e              fill_grp;
    logic [CNT_W-1:0]  cnt_q;
    logic [LFSR_W-1:0] lfsr_q;
    logic              coin;
    logic              follow_bip;
    logic              cnt_up;
    logic              cnt_dn;
    logic              mru_d;

    insdu_classify #(.SET_W(SET_W), .GROUP_W(GROUP_W)) u_miss_cls (
        .set_idx (miss_set),
        .grp     (miss_grp)
    );

    insdu_classify #(.SET_W(SET_W), .GROUP_W(GROUP_W)) u_fill_cls (
        .set_idx (fill_set),
        .grp     (fill_grp)
    );

    insdu_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr_q)
    );

    assign cnt_up = miss_valid && (miss_grp == GRP_LEAD_LRU);
    assign cnt_dn = miss_valid && (miss_grp == GRP_LEAD_BIP);

    insdu_duel_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .up    (cnt_up),
        .dn    (cnt_dn),
        .cnt   (cnt_q)
    );

    assign coin       = (lfsr_q[EPS_W-1:0] == '0);
    assign follow_bip = cnt_q[CNT_W-1];

    // R2, R3, R7, R10: decision from the pre-update counter
    always_comb begin
        unique case (fill_grp)
            GRP_LEAD_LRU: mru_d = 1'b1;
            GRP_LEAD_BIP: mru_d = coin;
            GRP_FOLLOW:   mru_d = follow_bip ? coin : 1'b1;
            default:      mru_d = 1'b1;
        endcase
    end

    // R8: registered answer one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_ack <= 1'b0;
            fill_mru <= 1'b0;
        end else begin
            fill_ack <= fill_valid;
            fill_mru <= fill_valid && mru_d;
        end
    end
endmodule

// File: rtl/insertion_duel_chk.sv
module insertion_duel_chk #(
    parameter int SET_W   = 10,
    parameter int GROUP_W = 5,
    parameter int CNT_W   = 10,
    parameter int LFSR_W  = 16,
    parameter int EPS_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic [SET_W-1:0]  miss_set,
    input logic              fill_valid,
    input logic [SET_W-1:0]  fill_set,
    input logic              fill_ack,
    input logic              fill_mru,
    input logic [CNT_W-1:0]  cnt,
    input logic [LFSR_W-1:0] lfsr
);
    localparam logic [GROUP_W-1:0] S_LRU = '0;
    localparam logic [GROUP_W-1:0] S_BIP = '1;
    localparam logic [CNT_W-1:0]   C_MAX = '1;
    localparam logic [CNT_W-1:0]   C_MIN = '0;

    logic f_lru, f_bip, f_fol, m_lru, m_bip, m_fol;
    assign f_lru = fill_set[GROUP_W-1:0] == S_LRU;
    assign f_bip = fill_set[GROUP_W-1:0] == S_BIP;
    assign f_fol = !f_lru && !f_bip;
    assign m_lru = miss_set[GROUP_W-1:0] == S_LRU;
    assign m_bip = miss_set[GROUP_W-1:0] == S_BIP;
    assign m_fol = !m_lru && !m_bip;

    assert_ack_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> fill_ack);
    assert_ack_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> !fill_ack);
    assert_mru_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_ack |-> !fill_mru);
    assert_lead_lru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && f_lru) |=> fill_mru);
    assert_lead_bip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && f_bip && lfsr[EPS_W-1:0] != '0) |=> !fill_mru);
    assert_follow_lru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && f_fol && !cnt[CNT_W-1]) |=> fill_mru);
    assert_follower_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_valid || m_fol) |=> $stable(cnt));
    assert_sat_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && m_lru && cnt == C_MAX) |=> (cnt == C_MAX));
    assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && m_bip && cnt == C_MIN) |=> (cnt == C_MIN));
    assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);
endmodule

bind insertion_duel_ctrl insertion_duel_chk #(
    .SET_W(SET_W), .GROUP_W(GROUP_W), .CNT_W(CNT_W), .LFSR_W(LFSR_W), .EPS_W(EPS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_set   (miss_set),
    .fill_valid (fill_valid),
    .fill_set   (fill_set),
    .fill_ack   (fill_ack),
    .fill_mru   (fill_mru),
    .cnt        (cnt_q),
    .lfsr       (lfsr_q)
);

// File: tb/insertion_duel_ctrl_test.sv
module insertion_duel_ctrl_test;
    localparam int SW = 10;
    localparam int CMAX = 1023;
    localparam int CMID = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 1'b0;
    logic [SW-1:0] miss_set = '0;
    logic fill_valid = 1'b0;
    logic [SW-1:0] fill_set = '0;
    logic fill_ack, fill_mru;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [15:0] m_lfsr;
    int m_cnt;
    string tag;

    always #10 clk = ~clk;

    insertion_duel_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_set(miss_set),
        .fill_valid(fill_valid), .fill_set(fill_set),
        .fill_ack(fill_ack), .fill_mru(fill_mru)
    );

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        logic [15:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ 16'hB400;
        return n;
    endfunction

    function automatic bit want_mru(input logic [SW-1:0] s);
        bit c;
        c = (m_lfsr[4:0] == 5'd0);
        if (s[4:0] == 5'd0)  return 1'b1;
        if (s[4:0] == 5'd31) return c;
        return (m_cnt >= CMID) ? c : 1'b1;
    endfunction

    function automatic int cnt_after(input int c, input logic [SW-1:0] s);
        if (s[4:0] == 5'd0)  return (c < CMAX) ? c + 1 : c;
        if (s[4:0] == 5'd31) return (c > 0) ? c - 1 : c;
        return c;
    endfunction

    function automatic logic [SW-1:0] pick_follow();
        logic [SW-1:0] s;
        s = SW'($urandom);
        if (s[4:0] == 5'd0 || s[4:0] == 5'd31) s[4:0] = 5'd7;
        return s;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b (phase %s)", req, act, exp, tag);
        end
    endtask

    // drive at negedge, step models at posedge, compare at next negedge
    task automatic cycle(input bit mv, input logic [SW-1:0] ms,
                         input bit fv, input logic [SW-1:0] fs, input string req);
        bit e_mru;
        miss_valid = mv; miss_set = ms;
        fill_valid = fv; fill_set = fs;
        e_mru = fv ? want_mru(fs) : 1'b0;
        @(posedge clk);
        m_lfsr = lfsr_next(m_lfsr);
        if (mv) m_cnt = cnt_after(m_cnt, ms);
        @(negedge clk);
        miss_valid = 1'b0; fill_valid = 1'b0;
        check("R8", fill_ack, fv);
        if (fv) check(req, fill_mru, e_mru);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int bip_coins;
        void'($urandom(32'd4242));
        tag = "reset";
        fill_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", fill_ack, 1'b0);
        check("R8", fill_mru, 1'b0);
        fill_valid = 1'b0;
        rst_n = 1'b1;
        m_lfsr = 16'hACE1;
        m_cnt = CMID;

        tag = "start";   // R6: followers begin bimodal
        for (int i = 0; i < 64; i++) cycle(0, '0, 1, pick_follow(), "R6");

        tag = "lru_lead"; // R1 R2
        for (int i = 0; i < 32; i++) cycle(0, '0, 1, SW'(($urandom % 32) * 32), "R2");

        tag = "bip_lead"; // R1 R3, R9 timing of draws
        bip_coins = 0;
        for (int i = 0; i < 200; i++) begin
            cycle(0, '0, 1, SW'(($urandom % 32) * 32 + 31), "R3");
            if (fill_mru) bip_coins++;
        end
        check("R9", bip_coins > 0, 1'b1);

        tag = "follow_miss"; // R4
        for (int i = 0; i < 120; i++) cycle(1, pick_follow(), 1, pick_follow(), "R4");

        tag = "sat_high"; // R5
        for (int i = 0; i < 600; i++) cycle(1, SW'(($urandom % 32) * 32), 1, pick_follow(), "R5");
        for (int i = 0; i < 511; i++) cycle(1, SW'(($urandom % 32) * 32 + 31), 1, pick_follow(), "R5");
        tag = "midpoint"; // R7: counter at 512, one more drops top bit
        for (int i = 0; i < 8; i++) cycle(0, '0, 1, pick_follow(), "R7");
        cycle(1, 10'd31, 1, pick_follow(), "R10");
        for (int i = 0; i < 8; i++) cycle(0, '0, 1, pick_follow(), "R7");

        tag = "sat_low"; // R5
        for (int i = 0; i < 700; i++) cycle(1, SW'(($urandom % 32) * 32 + 31), 1, pick_follow(), "R5");
        for (int i = 0; i < 511; i++) cycle(1, SW'(($urandom % 32) * 32), 1, pick_follow(), "R5");
        tag = "same_cycle"; // R10: counter 511, LRU miss with fill
        cycle(1, 10'd64, 1, pick_follow(), "R10");
        for (int i = 0; i < 16; i++) cycle(0, '0, 1, pick_follow(), "R7");

        tag = "random";
        for (int i = 0; i < 3000; i++) begin
            logic [SW-1:0] ms, fs;
            ms = SW'($urandom);
            fs = SW'($urandom);
            if (($urandom % 2) == 0) ms[4:0] = (($urandom % 2) == 0) ? 5'd0 : 5'd31;
            if (($urandom % 4) == 0) fs[4:0] = (($urandom % 2) == 0) ? 5'd0 : 5'd31;
            cycle(bit'($urandom % 2), ms, bit'($urandom % 2), fs, "R7");
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule